// File: doc/BRIEF.md
# EEPROM Write-Protection Gate

This block stands between the host-side strobes of a non-volatile memory and its page-write controller. It decides, cycle by cycle, whether a write attempt may reach the controller. Three independent guards apply. A supply-good indication (already digital) must be high. A power-on lockout timer must have run its full delay since that indication last became high. The strobe levels must describe a write: chip enable low, write enable low and output enable high.

Chip enable and write enable each pass through a minimum-pulse-width filter. A low level reaches the controller only after it has been seen on a fixed number of consecutive clock samples. A return to high passes at once, so a write ends promptly. The outputs are an active-low gated write strobe and a write-allowed flag. The flag means the supply and lockout guards are satisfied and output enable is not blocking. All inputs are taken to be synchronous to the free-running clock.

Top module: `wp_write_gate`

## Requirements
- R1: While `supply_ok` is low, `write_ok` is low and `we_gated_n` is high in the same cycle, whatever the strobes do.
- R2: After `supply_ok` rises, `write_ok` goes high once `DELAY_CYCLES` rising clock edges have sampled `supply_ok` high and `rst` low, provided `oe_n` is high. It stays high while those conditions hold.
- R3: A low `supply_ok` lasting even a single clock sample clears the lockout timer. The full `DELAY_CYCLES` delay must then elapse again before `write_ok` returns high.
- R4: `we_gated_n` is high whenever `oe_n` is low, `ce_n` is high or `we_n` is high. `write_ok` is low while `oe_n` is low.
- R5: A low pulse on `we_n` or on `ce_n` that is sampled low on fewer than `GLITCH_SAMPLES` consecutive rising edges never drives `we_gated_n` low.
- R6: With the gate open, `we_gated_n` goes low in the cycle after the `GLITCH_SAMPLES`-th consecutive edge at which both `ce_n` and `we_n` were sampled low.
- R7: When `we_n` or `ce_n` returns high, `we_gated_n` goes high in that same cycle, with no filtering delay.
- R8: While `rst` is high, and after it until the lockout delay has expired, `write_ok` is low and `we_gated_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | High when the supply is above its write threshold |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| we_n | input | 1 | Write enable, active low |
| we_gated_n | output | 1 | Filtered and gated write strobe to the page-write controller, active low |
| write_ok | output | 1 | High when supply, lockout and output-enable guards all permit a write |

## Verification
The hardest case to reach is a lockout restart caused by a one-cycle supply dip partway through the delay. In that case the count must start over from zero rather than resume. The stimulus raises the supply, lets the timer run roughly halfway, then drops the supply for exactly one sample. It then counts the full delay again and expects the flag to rise only on the final cycle. Strobe pulses exactly one sample shorter than the filter length are applied on each strobe separately, with the other strobe held low. This shows that each filter rejects them on its own.

// File: rtl/wp_pkg.sv
package wp_pkg;

    // Filtered strobes handled by the gate, in bit order of strobe_vec_t.
    localparam int unsigned NUM_STROBES = 2;
    localparam int unsigned STB_CE      = 0;
    localparam int unsigned STB_WE      = 1;

    typedef logic [NUM_STROBES-1:0] strobe_vec_t;

    // Guards that feed the final gate decision.
    typedef struct packed {
        logic supply_good;   // supply indication high
        logic lockout_done;  // power-on delay expired
        logic oe_clear;      // output enable not blocking
    } guard_t;

    // Result of the gate.
    typedef struct packed {
        logic allowed;       // write-allowed flag
        logic strobe_n;      // gated active-low write strobe
    } gate_out_t;

    // Bits needed to hold a count from 0 up to limit inclusive.
    function automatic int unsigned count_bits(input int unsigned limit);
        int unsigned w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

    // All guards satisfied.
    function automatic logic guards_open(input guard_t g);
        return g.supply_good & g.lockout_done & g.oe_clear;
    endfunction

endpackage

// File: rtl/wp_por_timer.sv
module wp_por_timer
    import wp_pkg::*;
#(
    parameter int unsigned DELAY_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    output logic por_done
);

    localparam int unsigned CW = count_bits(DELAY_CYCLES);
    localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYCLES);

    logic [CW-1:0] elapsed;

    // Any reset or any sample of a low supply restarts the delay from zero.
    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            elapsed <= '0;
        end else if (elapsed != LIMIT) begin
            elapsed <= elapsed + CW'(1);
        end
    end

    assign por_done = (elapsed == LIMIT);

    AST_POR_RESTART: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !por_done);                              // R3

    AST_POR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (por_done && supply_ok) |=> por_done);                  // R2

    AST_POR_RISE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        $rose(por_done) |-> $past(supply_ok));                  // R2

    AST_POR_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !por_done);                                     // R8

endmodule

// File: rtl/wp_glitch_filter.sv
module wp_glitch_filter
    import wp_pkg::*;
#(
    parameter int unsigned SAMPLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_n,
    output logic filt_n
);

    localparam int unsigned CW = count_bits(SAMPLES);
    localparam logic [CW-1:0] FULL = CW'(SAMPLES);

    logic [CW-1:0] low_run;

    // Count consecutive low samples, saturating at the required length.
    always_ff @(posedge clk) begin
        if (rst || raw_n) begin
            low_run <= '0;
        end else if (low_run != FULL) begin
            low_run <= low_run + CW'(1);
        end
    end

    // Assertion passes only after a full run; release is immediate.
    assign filt_n = raw_n | (low_run != FULL);

    AST_FLT_NO_EARLY_PASS: assert property (@(posedge clk) disable iff (rst)
        $fell(filt_n) |-> $past(!raw_n));                       // R5

    AST_FLT_RESET_HIGH: assert property (@(posedge clk)
        rst |=> filt_n);                                        // R8

endmodule

// File: rtl/wp_gate_logic.sv
module wp_gate_logic
    import wp_pkg::*;
(
    input  guard_t      guards,
    input  strobe_vec_t strobes_n,
    output gate_out_t   result
);

    logic open;
    logic strobes_low;

    always_comb begin
        open            = guards_open(guards);
        strobes_low     = ~(|strobes_n);
        result.allowed  = open;
        result.strobe_n = ~(open & strobes_low);
    end

    always_comb begin
        AST_GATE_NEEDS_OPEN: assert (result.strobe_n || result.allowed); // R4
    end

endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate
    import wp_pkg::*;
#(
    parameter int unsigned DELAY_CYCLES   = 1250000,
    parameter int unsigned GLITCH_SAMPLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic we_gated_n,
    output logic write_ok
);

    logic        por_done;
    strobe_vec_t raw_n;
    strobe_vec_t filt_n;
    guard_t      guards;
    gate_out_t   result;

    assign raw_n[STB_CE] = ce_n;
    assign raw_n[STB_WE] = we_n;

    wp_por_timer #(
        .DELAY_CYCLES (DELAY_CYCLES)
    ) i_por (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .por_done  (por_done)
    );

    for (genvar s = 0; s < NUM_STROBES; s++) begin : g_filter
        wp_glitch_filter #(
            .SAMPLES (GLITCH_SAMPLES)
        ) i_flt (
            .clk    (clk),
            .rst    (rst),
            .raw_n  (raw_n[s]),
            .filt_n (filt_n[s])
        );
    end

    assign guards.supply_good  = supply_ok;
    assign guards.lockout_done = por_done;
    assign guards.oe_clear     = oe_n;

    wp_gate_logic i_gate (
        .guards    (guards),
        .strobes_n (filt_n),
        .result    (result)
    );

    assign we_gated_n = result.strobe_n;
    assign write_ok   = result.allowed;

    AST_GATE_LEVELS: assert property (@(posedge clk) disable iff (rst)
        !we_gated_n |-> (supply_ok && oe_n && !ce_n && !we_n));  // R4

    AST_GATE_SUPPLY_LOW: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> (!write_ok && we_gated_n));              // R1

    AST_GATE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($rose(we_n) || $rose(ce_n)) |-> we_gated_n);           // R7

    AST_GATE_FALL_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(we_gated_n) |-> ($past(!we_n) && $past(!ce_n)));  // R6

    AST_GATE_RESET: assert property (@(posedge clk)
        rst |=> (!write_ok && we_gated_n));                     // R8

endmodule

// File: tb/test_wp_write_gate.sv
module test_wp_write_gate;

    localparam int unsigned DLY = 20;
    localparam int unsigned NS  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b1;
    logic ce_n = 1'b0;
    logic oe_n = 1'b1;
    logic we_n = 1'b0;
    logic we_gated_n;
    logic write_ok;

    int tests  = 0;
    int fails  = 0;
    bit closed = 1'b0;

    typedef struct {
        logic  ok;
        logic  wen;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    wp_write_gate #(
        .DELAY_CYCLES   (DLY),
        .GLITCH_SAMPLES (NS)
    ) i_wp_write_gate (
        .clk        (clk),
        .rst        (rst),
        .supply_ok  (supply_ok),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .we_gated_n (we_gated_n),
        .write_ok   (write_ok)
    );

    // Driver: one cycle of stimulus plus the outputs expected in that cycle.
    task automatic step(input logic r, input logic s, input logic ce,
                        input logic oe, input logic we,
                        input logic eok, input logic ewen, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; supply_ok = s; ce_n = ce; oe_n = oe; we_n = we;
        e.ok = eok; e.wen = ewen; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares each cycle's outputs once they settle.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                tests++;
                if (write_ok !== e.ok) begin
                    fails++;
                    $display("FAIL %s write_ok actual=%b expected=%b", e.tag, write_ok, e.ok);
                end
                tests++;
                if (we_gated_n !== e.wen) begin
                    fails++;
                    $display("FAIL %s we_gated_n actual=%b expected=%b", e.tag, we_gated_n, e.wen);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);

        // R8: held in reset with strobes asserted
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0, 0, 1, "R8");

        // R2 / R8: lockout count after reset release, strobes idle
        for (int j = 0; j <= DLY + 2; j++)
            step(0, 1, 1, 1, 1, (j >= DLY), 1, (j >= DLY) ? "R2" : "R8");

        // R6: both strobes low, pass after NS samples
        for (int k = 0; k <= NS + 2; k++)
            step(0, 1, 0, 1, 0, 1, !(k >= NS), "R6");

        // R7: release of write enable is immediate
        step(0, 1, 0, 1, 1, 1, 1, "R7");
        for (int k = 0; k <= NS + 1; k++)
            step(0, 1, 0, 1, 0, 1, !(k >= NS), "R6");

        // R1: supply drop closes the gate at once
        step(0, 0, 0, 1, 0, 0, 1, "R1");

        // R3: partial count, one-cycle dip, then full delay again
        for (int j = 0; j < 8; j++) step(0, 1, 0, 1, 0, 0, 1, "R3");
        step(0, 0, 0, 1, 0, 0, 1, "R1");
        for (int j = 0; j <= DLY + 1; j++)
            step(0, 1, 0, 1, 0, (j >= DLY), !(j >= DLY), "R3");

        // R4: output enable low inhibits, then reopens
        step(0, 1, 0, 0, 0, 0, 1, "R4");
        step(0, 1, 0, 1, 0, 1, 0, "R4");

        // R5: short write-enable pulse
        step(0, 1, 0, 1, 1, 1, 1, "R7");
        for (int k = 0; k <= NS - 2; k++) step(0, 1, 0, 1, 0, 1, 1, "R5");
        step(0, 1, 0, 1, 1, 1, 1, "R5");

        // R4: chip enable high blocks a held write enable
        for (int k = 0; k <= NS + 1; k++) step(0, 1, 1, 1, 0, 1, 1, "R4");

        // R5: short chip-enable pulse
        for (int k = 0; k <= NS - 2; k++) step(0, 1, 0, 1, 0, 1, 1, "R5");
        step(0, 1, 1, 1, 0, 1, 1, "R5");

        // R6: chip enable held long enough
        for (int k = 0; k <= NS + 1; k++)
            step(0, 1, 0, 1, 0, 1, !(k >= NS), "R6");

        repeat (3) @(negedge clk);
        if (!closed) begin
            closed = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!closed) begin
            closed = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule